// File: doc/BRIEF.md
# Power-Up Strap Capture Sequencer

This block runs shared pads that first act as configuration straps and then carry clock outputs. When the supply becomes valid, signalled by a power-good input, the block keeps the pad drivers switched off for a settling window. During the window, external strap resistors set each pad's level. At the end of the window it stores each pad's level as a configuration bit. Only after that does it turn the drivers on, so the pads become outputs.

Five pads are sampled. Four of them give the frequency-select code. The fifth gives a mode bit, which decides whether one further shared pad drives a fixed reference clock or stays an input for the peripheral-clock stop request. The stored bits have no logic reset. They clear only when power-good drops, which models the supply being removed and applied again. The window length is a parameter counted in timebase cycles.

Top module: `strap_latch_seq`

## Requirements
- R1: While `pwr_good` is low, `fs_sel`, `mode_sel`, `pad_oe` and `ready` are all 0.
- R2: After `pwr_good` rises, `ready` and every `pad_oe` bit stay 0 through the first WINDOW_CYCLES-1 rising edges. The strap bits are captured on rising edge number WINDOW_CYCLES.
- R3: Each captured bit is the resolved level of its pad, as seen through a two-flop synchronizer. The pad levels are sampled two edges before the capture edge. Bit order on `pin_drv`/`pin_lvl` is [0]=FS0, [1]=FS1, [2]=FS2, [3]=FS3, [4]=MODE. `fs_sel` = bits [3:0] and `mode_sel` = bit [4].
- R4: `ready` and the pad enables assert exactly one rising edge after the capture edge. At the capture edge, `fs_sel` and `mode_sel` already hold the new bits while `ready` is still 0.
- R5: A pad whose `pin_drv` bit is 0 resolves to its pull default: FS3 resolves to 0, and FS0, FS1, FS2 and MODE resolve to 1.
- R6: Once captured, `fs_sel` and `mode_sel` ignore any later change on `pin_drv`/`pin_lvl` for as long as `pwr_good` stays high.
- R7: After `ready` asserts, `ready` and `pad_oe[4:0]` stay 1 until `pwr_good` falls.
- R8: `pad_oe[5]`, the enable of the shared reference/stop pad, is 1 only when `ready` is 1 and the captured mode bit is 1.
- R9: A fall and new rise of `pwr_good` clears the captured bits, restarts the full window and captures fresh pad levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock |
| pwr_good | input | 1 | Supply valid; low acts as an asynchronous clear |
| pin_drv | input | 5 | 1 = pad is pulled to a definite level by a strap resistor |
| pin_lvl | input | 5 | Pad level where it is driven |
| fs_sel | output | 4 | Captured frequency-select code |
| mode_sel | output | 1 | Captured mode bit |
| pad_oe | output | 6 | Driver enables: [4:0] strap pads, [5] shared reference/stop pad |
| ready | output | 1 | Straps captured and drivers on |

## Verification
The situation hardest to reach from the ports is a strap level that changes late inside the window. The value that gets captured then depends on the synchronizer depth and on the exact terminal edge. To reach it, the stimulus changes the pad levels a few edges after power-good rises in some power cycles, and expects the later value. It also scrambles the pads on every cycle after capture to show that the stored bits stay frozen. Many power-good cycles, with random and fully undriven pad patterns, cover the pull defaults and both mode choices.

// File: rtl/strap_pkg.sv
package strap_pkg;
    localparam int NUM_FS    = 4;
    localparam int NUM_STRAP = NUM_FS + 1;
    localparam int MODE_BIT  = NUM_FS;
    localparam int NUM_OE    = NUM_STRAP + 1;
    // pull defaults: FS3 pulled down, every other strap pulled up
    localparam logic [NUM_STRAP-1:0] PULL_DEFAULT = 5'b10111;

    typedef enum logic [1:0] {
        PH_SETTLE = 2'd0,
        PH_HOLD   = 2'd1,
        PH_DRIVE  = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e                 phase;
        logic [NUM_STRAP-1:0]   bits;
    } seq_s;
endpackage

// File: rtl/strap_resolve.sv
module strap_resolve #(
    parameter int WIDTH = 5,
    parameter logic [WIDTH-1:0] PULL = '1
) (
    input  logic [WIDTH-1:0] drv,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] res
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        always_comb begin
            res[i] = drv[i] ? lvl[i] : PULL[i];
        end
    end
endmodule

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             pwr_good,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_s;

    sync_s sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = din;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) sy_q <= '0;
        else           sy_q <= sy_d;
    end

    assign dout = sy_q.s2;

    // R3: second stage follows the first one edge later
    p_sync_chain_r3: assert property (@(posedge clk) disable iff (!pwr_good)
        $past(pwr_good) |=> sy_q.s2 == $past(sy_q.s1));
endmodule

// File: rtl/strap_window_timer.sv
module strap_window_timer #(
    parameter int CYCLES = 28636
) (
    input  logic clk,
    input  logic pwr_good,
    input  logic run,
    output logic tc
);
    localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 2;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tc    = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (run && !tc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) cnt_q <= '0;
        else           cnt_q <= cnt_d;
    end

    // R2: count never passes the terminal value
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!pwr_good)
        cnt_q <= LAST);
    // R2: while running and short of terminal, count advances by one
    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!pwr_good)
        (run && cnt_q != LAST) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/strap_latch_seq.sv
module strap_latch_seq
    import strap_pkg::*;
#(
    parameter int WINDOW_CYCLES = 28636
) (
    input  logic                 clk,
    input  logic                 pwr_good,
    input  logic [NUM_STRAP-1:0] pin_drv,
    input  logic [NUM_STRAP-1:0] pin_lvl,
    output logic [NUM_FS-1:0]    fs_sel,
    output logic                 mode_sel,
    output logic [NUM_OE-1:0]    pad_oe,
    output logic                 ready
);
    logic [NUM_STRAP-1:0] pin_res;
    logic [NUM_STRAP-1:0] pin_sync;
    logic                 win_run;
    logic                 win_tc;
    seq_s                 seq_d, seq_q;

    strap_resolve #(.WIDTH(NUM_STRAP), .PULL(PULL_DEFAULT)) u_resolve (
        .drv (pin_drv),
        .lvl (pin_lvl),
        .res (pin_res)
    );

    strap_sync #(.WIDTH(NUM_STRAP)) u_sync (
        .clk      (clk),
        .pwr_good (pwr_good),
        .din      (pin_res),
        .dout     (pin_sync)
    );

    assign win_run = (seq_q.phase == PH_SETTLE);

    strap_window_timer #(.CYCLES(WINDOW_CYCLES)) u_timer (
        .clk      (clk),
        .pwr_good (pwr_good),
        .run      (win_run),
        .tc       (win_tc)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.phase)
            PH_SETTLE: if (win_tc) begin
                seq_d.bits  = pin_sync;
                seq_d.phase = PH_HOLD;
            end
            PH_HOLD:   seq_d.phase = PH_DRIVE;
            PH_DRIVE:  seq_d.phase = PH_DRIVE;
            default:   seq_d.phase = PH_SETTLE;
        endcase
    end

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) seq_q <= '{phase: PH_SETTLE, bits: '0};
        else           seq_q <= seq_d;
    end

    always_comb begin
        ready    = (seq_q.phase == PH_DRIVE);
        fs_sel   = seq_q.bits[NUM_FS-1:0];
        mode_sel = seq_q.bits[MODE_BIT];
        pad_oe   = {ready & seq_q.bits[MODE_BIT], {NUM_STRAP{ready}}};
    end

    // R4: drivers come up only from the one-cycle hold after capture
    p_latch_first_r4: assert property (@(posedge clk) disable iff (!pwr_good)
        $rose(ready) |-> $past(seq_q.phase) == PH_HOLD);
    p_hold_once_r4: assert property (@(posedge clk) disable iff (!pwr_good)
        (seq_q.phase == PH_HOLD) |=> ready);
    // R6: captured bits frozen once driving
    p_frozen_r6: assert property (@(posedge clk) disable iff (!pwr_good)
        ready |=> $stable(seq_q.bits));
    // R7: ready is sticky until power-good drops
    p_sticky_r7: assert property (@(posedge clk) disable iff (!pwr_good)
        ready |=> ready);
    // R2: capture only on the timer's terminal cycle
    p_capture_tc_r2: assert property (@(posedge clk) disable iff (!pwr_good)
        (seq_q.phase == PH_SETTLE && !win_tc) |=> seq_q.phase == PH_SETTLE);
endmodule

// File: tb/sim_strap_latch_seq.sv
module sim_strap_latch_seq;
    localparam int W = 24;

    logic       clk = 1'b0;
    logic       pwr_good = 1'b0;
    logic [4:0] pin_drv = '0;
    logic [4:0] pin_lvl = '0;
    logic [3:0] fs_sel;
    logic       mode_sel;
    logic [5:0] pad_oe;
    logic       ready;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    strap_latch_seq #(.WINDOW_CYCLES(W)) u0 (
        .clk(clk), .pwr_good(pwr_good), .pin_drv(pin_drv), .pin_lvl(pin_lvl),
        .fs_sel(fs_sel), .mode_sel(mode_sel), .pad_oe(pad_oe), .ready(ready)
    );

    function automatic logic [4:0] resolve(input logic [4:0] d, input logic [4:0] l);
        return (d & l) | (~d & 5'b10111);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pcycle(input logic [4:0] d1, input logic [4:0] l1,
                          input bit late, input logic [4:0] d2, input logic [4:0] l2);
        logic [4:0] exp;
        bit quiet;
        @(negedge clk);
        pwr_good = 1'b0;
        pin_drv = d1;
        pin_lvl = l1;
        repeat (3) @(negedge clk);
        chk("R1 outputs cleared", {fs_sel, mode_sel, pad_oe, ready}, 32'h0);
        pwr_good = 1'b1;
        exp = resolve(d1, l1);
        quiet = 1'b1;
        for (int k = 1; k < W; k++) begin
            @(negedge clk);
            if (ready || pad_oe != 0) quiet = 1'b0;
            if (late && k == 3) begin
                pin_drv = d2;
                pin_lvl = l2;
                exp = resolve(d2, l2);
            end
        end
        chk("R2 quiet window", {31'd0, quiet}, 32'd1);
        @(negedge clk);
        chk("R3 R5 R9 captured straps", {27'd0, mode_sel, fs_sel}, {27'd0, exp});
        chk("R4 not yet ready at capture", {25'd0, ready, pad_oe}, 32'h0);
        @(negedge clk);
        chk("R4 ready next edge", {31'd0, ready}, 32'd1);
        chk("R8 R7 pad enables", {26'd0, pad_oe}, {26'd0, exp[4], 5'h1f});
        for (int j = 0; j < 12; j++) begin
            pin_drv = 5'($urandom);
            pin_lvl = 5'($urandom);
            @(negedge clk);
        end
        chk("R6 straps frozen", {27'd0, mode_sel, fs_sel}, {27'd0, exp});
        chk("R7 still driving", {25'd0, ready, pad_oe}, {25'd0, 1'b1, exp[4], 5'h1f});
    endtask

    initial begin
        void'($urandom(32'd1234));
        pcycle(5'h00, 5'h00, 1'b0, 5'h00, 5'h00);   // R5: all undriven
        pcycle(5'h1f, 5'h00, 1'b0, 5'h00, 5'h00);   // mode 0, shared pad stays input
        pcycle(5'h1f, 5'h1f, 1'b0, 5'h00, 5'h00);
        pcycle(5'h08, 5'h08, 1'b0, 5'h00, 5'h00);   // R5: FS3 driven high, rest pulled
        pcycle(5'h1f, 5'h00, 1'b1, 5'h1f, 5'h1f);   // R3: late change in window
        pcycle(5'h00, 5'h00, 1'b1, 5'h1f, 5'h05);   // R9: fresh sample after cycle
        for (int n = 0; n < 30; n++) begin
            pcycle(5'($urandom), 5'($urandom), 1'($urandom),
                   5'($urandom), 5'($urandom));
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule